// File: doc/BRIEF.md
# Card Clock Divider Selector

This block derives the enable for a memory-card bus clock from a source clock. It divides by a power of two taken from an uneven set: 1, 2, 4, 8, 16, 32, 128 or 512. Ratios of 64 and 256 are not in the set. The source frequency is given as a 4-bit code. Some codes mean the source does not run. For those codes the block gates its output off and drops a valid flag. The divided clock appears as a single-cycle enable pulse in the source domain. Downstream logic uses it to advance the card bus.

There are two ways to choose the ratio:

- **Field mode.** The ratio comes from a 4-bit field at the top of a 32-bit divider configuration word.
- **Auto mode.** A helper picks the ratio from a requested frequency in kHz. The helper also returns a copy of the divider word with its choice written into the field, so that software-visible state can be updated without disturbing the other bits.

A new ratio never cuts a period short. It takes effect only once the period in progress has finished.

Top module: `ckdiv_card_clk`

## Requirements
- R1: The source code is bits 19:16 of `src_cfg_word`. Codes 1 to 7 are running sources, and `clk_valid` is high from the cycle after such a code is sampled. Codes 0 and 8 to 15 are stopped sources: from the cycle after such a code is sampled, `clk_valid` and `card_clk_en` are both low. Both outputs are low during reset.
- R2: The divider field is bits 31:28 of `div_cfg_word`. Its low three bits select the ratio: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 4 gives 16, 5 gives 32, 6 gives 128 and 7 gives 512. Bit 31 has no effect on the ratio.
- R3: While `clk_valid` is high and the ratio is N, `card_clk_en` is a one-cycle pulse every N cycles. The first pulse falls in the N-th cycle in which `clk_valid` is high.
- R4: With a ratio of 1, `card_clk_en` stays high on every cycle in which `clk_valid` is high.
- R5: A ratio change made during a period does not alter that period. The pulse that ends the period comes at the old spacing, and the following intervals use the new ratio.
- R6: Source frequencies in kHz are 33000 for code 0 and 10000 for code 1. For codes c from 2 to 15 the frequency is (5c+10)·1000. `auto_div_idx` is the lowest index i from 0 to 6 for which `req_freq_khz` ≥ source_khz >> log2(ratio(i)), with the shift computed as an integer shift. If no index qualifies, `auto_div_idx` is 7. When `auto_sel` is 1, the ratio is taken from `auto_div_idx` instead of from the field.
- R7: Bit 3 of `auto_div_idx` is always 0. `div_cfg_word_upd` equals `div_cfg_word` with bits 31:28 replaced by `auto_div_idx`; bits 27:0 are unchanged.
- R8: A request below source/512 (for example 0 kHz) selects index 7, the slowest clock.
- R9: If the source code becomes a stopped code in the middle of a period, no further pulse occurs. When a running code returns, counting restarts from zero, so the first pulse falls in the N-th valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_cfg_word | input | 32 | Source configuration word; the source code is in bits 19:16 |
| div_cfg_word | input | 32 | Divider configuration word; the divider field is in bits 31:28 |
| auto_sel | input | 1 | 1: take the ratio from the auto helper; 0: take it from the field |
| req_freq_khz | input | FREQ_W | Requested card clock frequency in kHz |
| card_clk_en | output | 1 | Divided-clock enable pulse |
| clk_valid | output | 1 | High while the divider runs from a working source |
| auto_div_idx | output | 4 | Divider index chosen by the auto helper |
| div_cfg_word_upd | output | 32 | Divider word with the auto choice written into bits 31:28 |

## Verification
Several properties are checked on every cycle:

- The enable stays quiet whenever the valid flag is low.
- A stopped code always drops the valid flag one cycle later.
- The period counter never passes the end of its period.
- The active ratio holds steady until a period boundary.
- A ratio of 1 keeps the enable high.
- Both bounds of the auto choice hold: its own threshold is met, and the threshold one index faster is not.

Some behaviours can only be shown by the bench's scenarios. These are:

- the exact pulse spacing for each ratio, including the skipped 64 and 256;
- the point at which a mid-period ratio change lands;
- the restart after a source outage;
- the field positions in both configuration words;
- the integer rounding of the auto thresholds.

// File: rtl/ckdiv_pkg.sv
// Shared constants and lookup functions for the card clock divider.
// Assumes an 8-entry ratio set and 4-bit source codes.
package ckdiv_pkg;

    localparam int CKD_IDX_W     = 3;
    localparam int CKD_NUM_IDX   = 8;
    localparam int CKD_SHIFT_W   = 4;
    localparam int CKD_MAX_SHIFT = 9;
    localparam int CKD_CODE_W    = 4;
    localparam int CKD_KHZ_W     = 17;

    typedef logic [CKD_IDX_W-1:0]   ckd_idx_t;
    typedef logic [CKD_SHIFT_W-1:0] ckd_shift_t;

    // Divider index to log2 of the ratio; 64 and 256 are absent from the set.
    function automatic ckd_shift_t ckd_idx_to_shift(input ckd_idx_t idx);
        case (idx)
            3'd6:    return 4'd7;
            3'd7:    return 4'd9;
            default: return ckd_shift_t'(idx);
        endcase
    endfunction

    // Source code to frequency in kHz.
    function automatic logic [CKD_KHZ_W-1:0] ckd_code_to_khz(input logic [CKD_CODE_W-1:0] code);
        int v;
        case (code)
            4'd0:    v = 33000;
            4'd1:    v = 10000;
            default: v = (int'(code) * 5 + 10) * 1000;
        endcase
        return CKD_KHZ_W'(v);
    endfunction

    // Only codes 1..7 drive a working source.
    function automatic logic ckd_code_runs(input logic [CKD_CODE_W-1:0] code);
        return (code >= 4'd1) && (code <= 4'd7);
    endfunction

endpackage

// File: rtl/ckdiv_src_decode.sv
// Source code decoder: turns the 4-bit source code into a frequency in kHz
// and a running flag. Purely combinational; assumes the code is stable
// relative to the source clock.
module ckdiv_src_decode
    import ckdiv_pkg::*;
#(
    parameter int CODE_W = CKD_CODE_W,
    parameter int KHZ_W  = CKD_KHZ_W
) (
    input  logic [CODE_W-1:0] src_code,
    output logic [KHZ_W-1:0]  src_khz,
    output logic              src_runs
);

    // Look up frequency and running status for the current code.
    always_comb begin
        src_khz  = KHZ_W'(ckd_code_to_khz(CKD_CODE_W'(src_code)));
        src_runs = ckd_code_runs(CKD_CODE_W'(src_code));
    end

endmodule

// File: rtl/ckdiv_auto_pick.sv
// Auto ratio picker: compares the requested frequency against the source
// frequency divided by every ratio except the slowest one. It returns the
// first (fastest) index whose divided frequency does not exceed the request,
// or the slowest index if none does. Combinational; the clock is used only
// by the assertions.
module ckdiv_auto_pick
    import ckdiv_pkg::*;
#(
    parameter int FREQ_W  = 20,
    parameter int KHZ_W   = CKD_KHZ_W,
    parameter int NUM_IDX = CKD_NUM_IDX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KHZ_W-1:0]  src_khz,
    input  logic [FREQ_W-1:0] req_khz,
    output ckd_idx_t          pick_idx
);

    localparam int CMP_W = (FREQ_W > KHZ_W) ? FREQ_W : KHZ_W;
    localparam int NCMP  = NUM_IDX - 1;

    logic [CMP_W-1:0] req_ext;
    logic [CMP_W-1:0] thr [NCMP];
    logic [NCMP-1:0]  hit;

    assign req_ext = CMP_W'(req_khz);

    // One threshold comparator per candidate index.
    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        localparam ckd_shift_t SH = ckd_idx_to_shift(ckd_idx_t'(i));
        assign thr[i] = CMP_W'(src_khz >> SH);
        assign hit[i] = (req_ext >= thr[i]);
    end

    // Priority select: the lowest qualifying index wins, else the slowest.
    always_comb begin
        pick_idx = ckd_idx_t'(NUM_IDX - 1);
        for (int i = NCMP - 1; i >= 0; i--) begin
            if (hit[i]) pick_idx = ckd_idx_t'(i);
        end
    end

    // R6: the chosen index meets its own threshold.
    p_pick_meets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_idx != ckd_idx_t'(NUM_IDX - 1)) |->
            (req_ext >= CMP_W'(src_khz >> ckd_idx_to_shift(pick_idx))));

    // R6: the next faster index would not have qualified.
    p_pick_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_idx != '0) |->
            (req_ext < CMP_W'(src_khz >> ckd_idx_to_shift(pick_idx - 3'd1))));

endmodule

// File: rtl/ckdiv_ratio_counter.sv
// Period counter: emits one tick per divided period. A requested ratio is
// adopted only when arming or at a period boundary, so no period is cut
// short. Stopping the source clears the counter, and re-arming starts
// again from zero.
module ckdiv_ratio_counter
    import ckdiv_pkg::*;
#(
    parameter int MAX_SHIFT = CKD_MAX_SHIFT,
    parameter int SHIFT_W   = CKD_SHIFT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [SHIFT_W-1:0] req_shift,
    output logic               tick,
    output logic               active
);

    localparam int CNT_W = MAX_SHIFT;

    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   last;
    logic [CNT_W:0]     span;
    logic [SHIFT_W-1:0] cur_shift;
    logic               armed;

    // Final count value of the current period.
    assign span = (CNT_W + 1)'(1) << cur_shift;
    assign last = CNT_W'(span - 1'b1);

    // Count source cycles and reload the ratio at arming and at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            cur_shift <= '0;
            armed     <= 1'b0;
        end else if (!run) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (!armed) begin
            armed     <= 1'b1;
            cur_shift <= req_shift;
            cnt       <= '0;
        end else if (cnt == last) begin
            cnt       <= '0;
            cur_shift <= req_shift;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Pulse in the final cycle of each period.
    assign tick   = armed && (cnt == last);
    assign active = armed;

    // R3: the count never runs past the end of its period.
    p_cnt_in_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt <= last));

    // R2: the active ratio stays inside the supported range.
    p_shift_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cur_shift <= SHIFT_W'(MAX_SHIFT)));

    // R4: a ratio of one keeps the tick high.
    p_unity_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cur_shift == '0) |-> tick);

    // R5: the ratio cannot change except at a boundary.
    p_hold_ratio_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && run && cnt != last) |=> $stable(cur_shift));

endmodule

// File: rtl/ckdiv_card_clk.sv
// Card clock divider selector (top). It extracts the source code and the
// divider field from their configuration words and selects the ratio from
// either the field or the auto picker. It drives the divided enable and the
// valid flag, and returns the divider word with the auto choice merged in.
// Assumes all inputs are synchronous to clk.
module ckdiv_card_clk
    import ckdiv_pkg::*;
#(
    parameter int FREQ_W  = 20,
    parameter int DIV_LSB = 28,
    parameter int SRC_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       src_cfg_word,
    input  logic [31:0]       div_cfg_word,
    input  logic              auto_sel,
    input  logic [FREQ_W-1:0] req_freq_khz,
    output logic              card_clk_en,
    output logic              clk_valid,
    output logic [3:0]        auto_div_idx,
    output logic [31:0]       div_cfg_word_upd
);

    logic [CKD_CODE_W-1:0] src_code;
    logic [3:0]            div_field;
    logic [CKD_KHZ_W-1:0]  src_khz;
    logic                  src_runs;
    ckd_idx_t              pick_idx;
    ckd_idx_t              sel_idx;
    ckd_shift_t            req_shift;

    assign src_code  = src_cfg_word[SRC_LSB +: CKD_CODE_W];
    assign div_field = div_cfg_word[DIV_LSB +: 4];

    ckdiv_src_decode #(
        .CODE_W (CKD_CODE_W),
        .KHZ_W  (CKD_KHZ_W)
    ) u_src (
        .src_code (src_code),
        .src_khz  (src_khz),
        .src_runs (src_runs)
    );

    ckdiv_auto_pick #(
        .FREQ_W  (FREQ_W),
        .KHZ_W   (CKD_KHZ_W),
        .NUM_IDX (CKD_NUM_IDX)
    ) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_khz  (src_khz),
        .req_khz  (req_freq_khz),
        .pick_idx (pick_idx)
    );

    // Choose the index source; the top field bit plays no part in the ratio.
    always_comb begin
        sel_idx   = auto_sel ? pick_idx : div_field[CKD_IDX_W-1:0];
        req_shift = ckd_idx_to_shift(sel_idx);
    end

    ckdiv_ratio_counter #(
        .MAX_SHIFT (CKD_MAX_SHIFT),
        .SHIFT_W   (CKD_SHIFT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (src_runs),
        .req_shift (req_shift),
        .tick      (card_clk_en),
        .active    (clk_valid)
    );

    // Merge the auto choice into the divider word, leaving the other bits as they are.
    always_comb begin
        auto_div_idx                  = {1'b0, pick_idx};
        div_cfg_word_upd              = div_cfg_word;
        div_cfg_word_upd[DIV_LSB +: 4] = auto_div_idx;
    end

    // R1: no enable pulse while the clock is flagged invalid.
    p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_valid |-> !card_clk_en);

    // R9: a stopped source drops the valid flag on the next cycle.
    p_stop_drops_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !src_runs |=> !clk_valid);

endmodule

// File: tb/ckdiv_card_clk_test.sv
module ckdiv_card_clk_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src_cfg_word;
    logic [31:0] div_cfg_word;
    logic        auto_sel;
    logic [19:0] req_freq_khz;
    logic        card_clk_en;
    logic        clk_valid;
    logic [3:0]  auto_div_idx;
    logic [31:0] div_cfg_word_upd;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int exp_q[$];

    ckdiv_card_clk #(.FREQ_W(20), .DIV_LSB(28), .SRC_LSB(16)) uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .src_cfg_word     (src_cfg_word),
        .div_cfg_word     (div_cfg_word),
        .auto_sel         (auto_sel),
        .req_freq_khz     (req_freq_khz),
        .card_clk_en      (card_clk_en),
        .clk_valid        (clk_valid),
        .auto_div_idx     (auto_div_idx),
        .div_cfg_word_upd (div_cfg_word_upd)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: pops the expected pulse cycles and compares them with the enable.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            while (exp_q.size() > 0 && exp_q[0] < cyc) begin
                chk(1'b0, "R3 missing pulse", 0, exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (card_clk_en) begin
                if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                    chk(1'b1, "R3", cyc, cyc);
                    void'(exp_q.pop_front());
                end else begin
                    chk(1'b0, "R3/R1 unexpected pulse", cyc,
                        (exp_q.size() > 0) ? exp_q[0] : -1);
                end
            end
        end
    end

    // Driver helper: queue k pulses spaced n apart, after cycle t0.
    task automatic push_train(input int t0, input int n, input int k);
        for (int i = 1; i <= k; i++) exp_q.push_back(t0 + i * n);
    endtask

    task automatic wait_to(input int t);
        while (cyc != t) @(negedge clk);
    endtask

    function automatic int ref_khz(input int code);
        case (code)
            0: return 33000;  1: return 10000;  2: return 20000;  3: return 25000;
            4: return 30000;  5: return 35000;  6: return 40000;  7: return 45000;
            8: return 50000;  9: return 55000;  10: return 60000; 11: return 65000;
            12: return 70000; 13: return 75000; 14: return 80000; default: return 85000;
        endcase
    endfunction

    function automatic int ref_shift(input int idx);
        case (idx)
            0: return 0; 1: return 1; 2: return 2; 3: return 3;
            4: return 4; 5: return 5; 6: return 7; default: return 9;
        endcase
    endfunction

    function automatic int ref_pick(input int code, input int req);
        for (int i = 0; i < 7; i++)
            if (req >= (ref_khz(code) >> ref_shift(i))) return i;
        return 7;
    endfunction

    task automatic auto_case(input int code, input int req, input string tag);
        int e;
        src_cfg_word = {12'hABC, code[3:0], 16'h1234};
        req_freq_khz = req[19:0];
        #1;
        e = ref_pick(code, req);
        chk(int'(auto_div_idx) == e, tag, int'(auto_div_idx), e);
        chk(div_cfg_word_upd == {e[3:0], div_cfg_word[27:0]}, "R7",
            int'(div_cfg_word_upd[31:28]), e);
        chk(div_cfg_word_upd[27:0] == div_cfg_word[27:0], "R7 low bits",
            int'(div_cfg_word_upd[27:0]), int'(div_cfg_word[27:0]));
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int t;
        rst_n        = 1'b0;
        src_cfg_word = 32'h0000_0000;
        div_cfg_word = 32'h0000_0000;
        auto_sel     = 1'b0;
        req_freq_khz = '0;
        repeat (3) @(negedge clk);
        chk(card_clk_en == 1'b0, "R1 reset en", int'(card_clk_en), 0);
        chk(clk_valid == 1'b0, "R1 reset valid", int'(clk_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(clk_valid == 1'b0, "R1 code0 stopped", int'(clk_valid), 0);

        // R1/R2/R3: code 3 with other bits set, divider index 3 -> ratio 8.
        src_cfg_word = 32'hFFF3_FFFF;
        div_cfg_word = 32'h3ABC_DEF0;
        t = cyc;
        push_train(t, 8, 4);
        @(negedge clk);
        chk(clk_valid == 1'b1, "R1 code3 runs", int'(clk_valid), 1);
        wait_to(t + 32);

        // R5 at a boundary: switch to ratio 2.
        t = cyc;
        div_cfg_word = 32'h1000_0000;
        push_train(t, 2, 5);
        wait_to(t + 10);

        // R4: ratio 1 keeps the enable high.
        t = cyc;
        div_cfg_word = 32'h0FFF_FFFF;
        push_train(t, 1, 6);
        wait_to(t + 6);

        // R2: bit 31 ignored (field 0xB is ratio 8), then R5 mid-period change to 32.
        t = cyc;
        div_cfg_word = 32'hB000_0000;
        push_train(t, 8, 2);
        wait_to(t + 19);
        div_cfg_word = 32'h5000_0000;
        exp_q.push_back(t + 24);
        exp_q.push_back(t + 56);
        wait_to(t + 56);

        // R2: ratios 16, 128 and 512 (64 and 256 skipped).
        t = cyc;
        div_cfg_word = 32'h4000_0000;
        push_train(t, 16, 2);
        wait_to(t + 32);
        t = cyc;
        div_cfg_word = 32'h6000_0000;
        push_train(t, 128, 1);
        wait_to(t + 128);
        t = cyc;
        div_cfg_word = 32'h7000_0000;
        push_train(t, 512, 1);
        wait_to(t + 512);

        // R9: stop mid-period, then restart from zero.
        t = cyc;
        div_cfg_word = 32'h2000_0000;
        push_train(t, 4, 1);
        wait_to(t + 6);
        src_cfg_word = 32'h0009_0000;
        @(negedge clk);
        chk(clk_valid == 1'b0, "R9 stop drops valid", int'(clk_valid), 0);
        repeat (20) @(negedge clk);
        t = cyc;
        src_cfg_word = 32'h0007_0000;
        push_train(t, 4, 3);
        wait_to(t + 12);

        // R1: sweep all codes with ratio 512 so no pulse falls in the window.
        div_cfg_word = 32'h7000_0000;
        for (int c = 0; c < 16; c++) begin
            src_cfg_word = {12'h000, c[3:0], 16'hFFFF};
            @(negedge clk);
            chk(clk_valid == ((c >= 1 && c <= 7) ? 1'b1 : 1'b0), "R1 code sweep",
                int'(clk_valid), (c >= 1 && c <= 7) ? 1 : 0);
        end

        // R6/R7/R8: auto selection against stopped sources (no pulses).
        div_cfg_word = 32'h5A5A_5A5A;
        auto_sel = 1'b1;
        auto_case(0, 33000, "R6 exact source");
        auto_case(0, 32999, "R6 just below");
        auto_case(0, 16499, "R6 idx2");
        auto_case(0, 257,   "R6 rounding idx6");
        auto_case(0, 100,   "R8 below min");
        auto_case(15, 0,    "R8 zero request");
        auto_case(15, 2000, "R6 skip to idx6");
        auto_case(12, 400000, "R6 above source");
        auto_case(9, 1800,  "R6 idx5");

        // R6: auto choice drives the ratio (25000 kHz, 3200 kHz -> ratio 8).
        div_cfg_word = 32'h0000_0000;
        req_freq_khz = 20'd3200;
        t = cyc;
        src_cfg_word = 32'h0003_0000;
        push_train(t, 8, 3);
        #1;
        chk(auto_div_idx == 4'd3, "R6 auto idx", int'(auto_div_idx), 3);
        wait_to(t + 24);

        @(negedge clk);
        chk(exp_q.size() == 0, "R3 pending pulses", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule